// File: doc/BRIEF.md
# Receive FIFO to Ring Buffer Write Scheduler

This block drains received packet bytes from a local receive FIFO into a circular buffer in host memory. It watches the number of bytes of the current packet held in the FIFO and a flag that says the packet's last byte has arrived. From these it decides when draining may begin. Once draining has started, it issues write bursts, each an address and a byte length, through a valid/ready handshake toward a memory write port. The producer of the FIFO takes away the granted bytes when a burst is accepted.

The burst size limit, the start threshold and the ring size are each chosen by a small code. The handling of a packet that reaches the end of the ring is chosen by a mode bit. In folding mode, the packet continues at the ring start. In linear mode, the packet runs past the ring end into reserved memory, and the next packet begins at the spilled amount past the ring start. Before each burst, the block compares the burst against the free space between its write offset and the host read offset, and it holds the burst back until it fits.

Top module: `rx_ring_dma_sched`

## Requirements
- R1: With threshold code c in 0..6, draining starts once the FIFO holds at least 16·2^c bytes of the current packet, and it does not start below that level unless the packet is complete.
- R2: Threshold code 7 disables the byte level, so draining starts only when the end-of-packet flag is set.
- R3: When the end-of-packet flag is set and the count is nonzero, draining starts even if the count is below the byte level.
- R4: Each burst length is the smallest of the FIFO count and the burst limit. For burst code b in 0..6 the limit is 16·2^b bytes; code 7 sets no limit.
- R5: Ring code r in 0..3 selects a ring span of 8192·2^r + 16 bytes. This span is where folding and spill are measured.
- R6: In folding mode (mode bit 0), a burst that would cross the ring end is cut there, and the remainder is issued from the ring base. Every burst address is the ring base plus the write offset.
- R7: In linear mode (mode bit 1), a packet writes past the ring end without a cut. When the write offset ends X bytes past the span, the next packet starts at base + X.
- R8: With ring code 3, the mode bit is ignored and the block folds as in R6.
- R9: No burst is issued while its length exceeds the free space. The free space is the read offset minus the write position minus 1, modulo the span, where the write position is the offset reduced by one span if the offset is past the end. The block issues the burst once the read offset moves far enough.
- R10: The configuration codes and the mode bit are captured only while no packet is in progress. Changes made during a packet do not alter that packet's bursts.
- R11: While the request is valid and not accepted, its address and length stay constant.
- R12: After reset there is no request, and the write offset is 0, so the first burst goes to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thr_code | input | 3 | Start threshold code |
| cfg_ring_code | input | 2 | Ring span code |
| cfg_burst_code | input | 3 | Burst size limit code |
| cfg_wrap_linear | input | 1 | 1 = write past ring end, 0 = fold at ring end |
| fifo_cnt | input | CNT_W | Bytes of the current packet held in the FIFO |
| fifo_eop | input | 1 | Last byte of the current packet is in the FIFO |
| ring_base | input | ADDR_W | Host address of the ring start |
| host_rd_off | input | OFF_W | Host read offset within the ring |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | CNT_W | Burst length in bytes |

## Verification
A corrupted write offset shows up at the next burst's address. It also shifts the free-space result, so a burst can stall that should have gone, or go when it should have stalled. A wrong captured code shows up as a wrong length on the first burst after the start, two cycles after the start condition. A lost end-of-ring adjustment appears at the first burst of the following packet, as an address that folds or spills by the wrong amount. A wrong start decision shows up as a request that appears or stays absent within a few cycles of the FIFO count crossing the level.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [1:0] {
        DMA_IDLE,
        DMA_ACTIVE,
        DMA_BURST
    } dma_st_e;

endpackage

// File: rtl/rxdma_start_detect.sv
module rxdma_start_detect #(
    parameter int CNT_W     = 14,
    parameter int UNIT_LOG2 = 4
) (
    input  logic [2:0]       thr_code,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             fifo_eop,
    output logic             start
);
    localparam logic [2:0] THR_OFF = 3'd7;

    logic [31:0] level;
    logic        level_hit;

    always_comb begin
        level     = 32'd1 << (UNIT_LOG2 + 32'(thr_code));
        level_hit = (thr_code != THR_OFF) && (32'(fifo_cnt) >= level);
        start     = (fifo_cnt != '0) && (fifo_eop || level_hit);
    end
endmodule

// File: rtl/rxdma_burst_sizer.sv
module rxdma_burst_sizer #(
    parameter int CNT_W      = 14,
    parameter int OFF_W      = 18,
    parameter int UNIT_LOG2  = 4,
    parameter int RING_LOG2  = 13,
    parameter int RING_SLACK = 16
) (
    input  logic [2:0]       burst_code,
    input  logic [1:0]       ring_code,
    input  logic             wrap_linear,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [OFF_W-1:0] rd_off,
    input  logic [CNT_W-1:0] fifo_cnt,
    output logic [OFF_W-1:0] ring_len,
    output logic [OFF_W-1:0] burst_lim,
    output logic [OFF_W-1:0] burst_len,
    output logic [OFF_W-1:0] free_bytes,
    output logic             fits
);
    localparam logic [2:0] BURST_UNLIM = 3'd7;

    logic [31:0]      span32;
    logic [OFF_W-1:0] avail;
    logic [OFF_W-1:0] len_fifo;
    logic [OFF_W-1:0] to_end;
    logic [OFF_W-1:0] pos;

    always_comb begin
        span32    = (32'd1 << (RING_LOG2 + 32'(ring_code))) + 32'(RING_SLACK);
        ring_len  = span32[OFF_W-1:0];
        burst_lim = (burst_code == BURST_UNLIM) ? '1
                  : OFF_W'(32'd1 << (UNIT_LOG2 + 32'(burst_code)));
        avail     = OFF_W'(fifo_cnt);
        len_fifo  = (avail < burst_lim) ? avail : burst_lim;
        to_end    = (wr_off < ring_len) ? (ring_len - wr_off) : '0;
        if (!wrap_linear && (to_end < len_fifo)) begin
            burst_len = to_end;
        end else begin
            burst_len = len_fifo;
        end
        pos = (wr_off >= ring_len) ? (wr_off - ring_len) : wr_off;
        if (rd_off > pos) begin
            free_bytes = rd_off - pos - 1'b1;
        end else begin
            free_bytes = ring_len - pos + rd_off - 1'b1;
        end
        fits = (burst_len != '0) && (burst_len <= free_bytes);
    end
endmodule

// File: rtl/rx_ring_dma_sched.sv
module rx_ring_dma_sched
    import rxdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 14,
    parameter int OFF_W      = 18,
    parameter int UNIT_LOG2  = 4,
    parameter int RING_LOG2  = 13,
    parameter int RING_SLACK = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_thr_code,
    input  logic [1:0]        cfg_ring_code,
    input  logic [2:0]        cfg_burst_code,
    input  logic              cfg_wrap_linear,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic              fifo_eop,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [OFF_W-1:0]  host_rd_off,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_len
);
    localparam logic [1:0] RING_MAX_CODE = 2'd3;

    typedef struct packed {
        dma_st_e          st;
        logic [2:0]       burst;
        logic [1:0]       ring;
        logic             wrap_lin;
        logic [OFF_W-1:0] wr_off;
        logic [OFF_W-1:0] len;
        logic             last;
    } sched_t;

    sched_t sch_d, sch_q;

    logic             start_now;
    logic [OFF_W-1:0] ring_len;
    logic [OFF_W-1:0] burst_lim;
    logic [OFF_W-1:0] burst_len;
    logic [OFF_W-1:0] free_bytes;
    logic             fits;
    logic [OFF_W-1:0] nxt_off;

    rxdma_start_detect #(
        .CNT_W     (CNT_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) i_start (
        .thr_code (cfg_thr_code),
        .fifo_cnt (fifo_cnt),
        .fifo_eop (fifo_eop),
        .start    (start_now)
    );

    rxdma_burst_sizer #(
        .CNT_W      (CNT_W),
        .OFF_W      (OFF_W),
        .UNIT_LOG2  (UNIT_LOG2),
        .RING_LOG2  (RING_LOG2),
        .RING_SLACK (RING_SLACK)
    ) i_sizer (
        .burst_code  (sch_q.burst),
        .ring_code   (sch_q.ring),
        .wrap_linear (sch_q.wrap_lin),
        .wr_off      (sch_q.wr_off),
        .rd_off      (host_rd_off),
        .fifo_cnt    (fifo_cnt),
        .ring_len    (ring_len),
        .burst_lim   (burst_lim),
        .burst_len   (burst_len),
        .free_bytes  (free_bytes),
        .fits        (fits)
    );

    always_comb begin
        sch_d   = sch_q;
        nxt_off = sch_q.wr_off + sch_q.len;
        unique case (sch_q.st)
            DMA_IDLE: begin
                sch_d.burst    = cfg_burst_code;
                sch_d.ring     = cfg_ring_code;
                sch_d.wrap_lin = cfg_wrap_linear && (cfg_ring_code != RING_MAX_CODE);
                if (start_now) begin
                    sch_d.st = DMA_ACTIVE;
                end
            end
            DMA_ACTIVE: begin
                if (fits) begin
                    sch_d.len  = burst_len;
                    sch_d.last = fifo_eop && (burst_len == OFF_W'(fifo_cnt));
                    sch_d.st   = DMA_BURST;
                end
            end
            DMA_BURST: begin
                if (req_ready) begin
                    if (!sch_q.wrap_lin && (nxt_off >= ring_len)) begin
                        nxt_off = nxt_off - ring_len;
                    end
                    if (sch_q.last) begin
                        if (sch_q.wrap_lin && (nxt_off >= ring_len)) begin
                            nxt_off = nxt_off - ring_len;
                        end
                        sch_d.st = DMA_IDLE;
                    end else begin
                        sch_d.st = DMA_ACTIVE;
                    end
                    sch_d.wr_off = nxt_off;
                end
            end
            default: sch_d.st = DMA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q <= '{st: DMA_IDLE, burst: 3'd0, ring: 2'd0, wrap_lin: 1'b0,
                       wr_off: '0, len: '0, last: 1'b0};
        end else begin
            sch_q <= sch_d;
        end
    end

    assign req_valid = (sch_q.st == DMA_BURST);
    assign req_addr  = ring_base + ADDR_W'(sch_q.wr_off);
    assign req_len   = sch_q.len[CNT_W-1:0];

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // R4
    burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((OFF_W'(req_len) <= burst_lim) && (req_len != '0)));

    // R6
    no_ring_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sch_q.wrap_lin) |-> ((sch_q.wr_off + sch_q.len) <= ring_len));

    // R9
    space_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> (sch_q.len <= $past(free_bytes)));

    // R8
    max_ring_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q.ring == RING_MAX_CODE) |-> !sch_q.wrap_lin);

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q.st != DMA_IDLE && sch_d.st != DMA_IDLE) |=> ($stable(sch_q.burst) && $stable(sch_q.ring)));
endmodule

// File: tb/test_rx_ring_dma_sched.sv
module test_rx_ring_dma_sched;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 14;
    localparam int OFF_W  = 18;
    localparam int NVEC   = 11;
    localparam logic [ADDR_W-1:0] BASE = 32'h1000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_thr_code = '0;
    logic [1:0]        cfg_ring_code = '0;
    logic [2:0]        cfg_burst_code = '0;
    logic              cfg_wrap_linear = 1'b0;
    logic [CNT_W-1:0]  fifo_cnt = '0;
    logic              fifo_eop = 1'b0;
    logic [ADDR_W-1:0] ring_base = BASE;
    logic [OFF_W-1:0]  host_rd_off = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [CNT_W-1:0]  req_len;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rx_ring_dma_sched i_rx_ring_dma_sched (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_thr_code    (cfg_thr_code),
        .cfg_ring_code   (cfg_ring_code),
        .cfg_burst_code  (cfg_burst_code),
        .cfg_wrap_linear (cfg_wrap_linear),
        .fifo_cnt        (fifo_cnt),
        .fifo_eop        (fifo_eop),
        .ring_base       (ring_base),
        .host_rd_off     (host_rd_off),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_addr        (req_addr),
        .req_len         (req_len)
    );

    // {thr, burst, cnt, eop, expect_valid, expect_len, req}
    localparam logic [39:0] VEC [NVEC] = '{
        {3'd0, 3'd7, 14'd15,   1'b0, 1'b0, 14'd0,    4'd1},
        {3'd0, 3'd7, 14'd16,   1'b0, 1'b1, 14'd16,   4'd1},
        {3'd3, 3'd0, 14'd127,  1'b0, 1'b0, 14'd0,    4'd1},
        {3'd3, 3'd0, 14'd128,  1'b0, 1'b1, 14'd16,   4'd4},
        {3'd6, 3'd6, 14'd1023, 1'b0, 1'b0, 14'd0,    4'd1},
        {3'd6, 3'd6, 14'd1024, 1'b0, 1'b1, 14'd1024, 4'd4},
        {3'd7, 3'd7, 14'd2000, 1'b0, 1'b0, 14'd0,    4'd2},
        {3'd7, 3'd7, 14'd40,   1'b1, 1'b1, 14'd40,   4'd2},
        {3'd6, 3'd7, 14'd5,    1'b1, 1'b1, 14'd5,    4'd3},
        {3'd2, 3'd1, 14'd100,  1'b0, 1'b1, 14'd32,   4'd4},
        {3'd1, 3'd7, 14'd200,  1'b0, 1'b1, 14'd200,  4'd4}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        req_ready = 1'b0;
        fifo_cnt  = '0;
        fifo_eop  = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (req_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic take(input string req, output logic [ADDR_W-1:0] a, output logic [CNT_W-1:0] l);
        bit g;
        wait_valid(g);
        if (!g) begin
            a = '1;
            l = '0;
            chk(req, 64'd0, 64'd1);
            fifo_cnt = '0;
        end else begin
            a = req_addr;
            l = req_len;
            req_ready = 1'b1;
            @(posedge clk);
            #1 req_ready = 1'b0;
            fifo_cnt = fifo_cnt - l;
        end
    endtask

    task automatic send_bulk(input int n);
        logic [ADDR_W-1:0] a;
        logic [CNT_W-1:0]  l;
        fifo_cnt = CNT_W'(n);
        fifo_eop = 1'b1;
        while (fifo_cnt != '0) take("R5", a, l);
        fifo_eop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a;
        logic [CNT_W-1:0]  l;
        bit                g;

        // R1 R2 R3 R4: start and sizing vectors
        for (int i = 0; i < NVEC; i++) begin
            cfg_thr_code   = VEC[i][39:37];
            cfg_burst_code = VEC[i][36:34];
            cfg_ring_code  = 2'd0;
            host_rd_off    = '0;
            do_reset();
            fifo_cnt = VEC[i][33:20];
            fifo_eop = VEC[i][19];
            repeat (6) @(negedge clk);
            chk($sformatf("R%0d vec%0d valid", VEC[i][3:0], i), 64'(req_valid), 64'(VEC[i][18]));
            if (VEC[i][18]) begin
                chk($sformatf("R%0d vec%0d len", VEC[i][3:0], i), 64'(req_len), 64'(VEC[i][17:4]));
            end
        end

        // R12: reset state and first address
        cfg_thr_code = 3'd7; cfg_burst_code = 3'd1; cfg_wrap_linear = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R12 valid after reset", 64'(req_valid), 64'd0);
        fifo_cnt = 14'd100; fifo_eop = 1'b1;
        take("R12", a, l);
        chk("R12 first addr", 64'(a), 64'(BASE));
        chk("R4 burst1 len", 64'(l), 64'd32);
        take("R4", a, l); take("R4", a, l); take("R4", a, l);
        chk("R4 tail addr", 64'(a), 64'(BASE + 32'd96));
        chk("R4 tail len", 64'(l), 64'd4);
        fifo_eop = 1'b0;

        // R6 R5: fold at span end 8208
        cfg_burst_code = 3'd7; cfg_ring_code = 2'd0; cfg_wrap_linear = 1'b0;
        host_rd_off = '0;
        do_reset();
        send_bulk(8192);
        host_rd_off = 18'd100;
        fifo_cnt = 14'd40; fifo_eop = 1'b1;
        take("R6", a, l);
        chk("R6 cut addr", 64'(a), 64'(BASE + 32'd8192));
        chk("R6 cut len", 64'(l), 64'd16);
        take("R6", a, l);
        chk("R6 fold addr", 64'(a), 64'(BASE));
        chk("R6 fold len", 64'(l), 64'd24);
        fifo_eop = 1'b0;

        // R7: linear spill, next packet at offset 24
        cfg_wrap_linear = 1'b1; host_rd_off = '0;
        do_reset();
        send_bulk(8192);
        host_rd_off = 18'd100;
        fifo_cnt = 14'd40; fifo_eop = 1'b1;
        take("R7", a, l);
        chk("R7 spill addr", 64'(a), 64'(BASE + 32'd8192));
        chk("R7 spill len", 64'(l), 64'd40);
        fifo_eop = 1'b0;
        fifo_cnt = 14'd8; fifo_eop = 1'b1;
        take("R7", a, l);
        chk("R7 next packet addr", 64'(a), 64'(BASE + 32'd24));
        fifo_eop = 1'b0;

        // R8: 64K ring folds despite linear mode
        cfg_ring_code = 2'd3; cfg_wrap_linear = 1'b1; host_rd_off = '0;
        do_reset();
        for (int p = 0; p < 8; p++) send_bulk(8192);
        host_rd_off = 18'd100;
        fifo_cnt = 14'd40; fifo_eop = 1'b1;
        take("R8", a, l);
        chk("R8 cut len", 64'(l), 64'd16);
        take("R8", a, l);
        chk("R8 fold addr", 64'(a), 64'(BASE));
        fifo_eop = 1'b0;

        // R9: stall until read offset frees space
        cfg_ring_code = 2'd0; cfg_wrap_linear = 1'b0; cfg_burst_code = 3'd1;
        host_rd_off = 18'd20;
        do_reset();
        fifo_cnt = 14'd32; fifo_eop = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 stalled", 64'(req_valid), 64'd0);
        host_rd_off = 18'd40;
        take("R9", a, l);
        chk("R9 released len", 64'(l), 64'd32);
        fifo_eop = 1'b0;

        // R10 R11: mid-packet config change, request hold
        cfg_thr_code = 3'd0; cfg_burst_code = 3'd1; host_rd_off = '0;
        do_reset();
        fifo_cnt = 14'd64; fifo_eop = 1'b0;
        wait_valid(g);
        a = req_addr;
        cfg_burst_code = 3'd0;
        repeat (3) @(negedge clk);
        chk("R11 held valid", 64'(req_valid), 64'd1);
        chk("R11 held addr", 64'(req_addr), 64'(a));
        take("R10", a, l);
        chk("R10 first len", 64'(l), 64'd32);
        take("R10", a, l);
        chk("R10 second len unchanged", 64'(l), 64'd32);
        chk("R10 second addr", 64'(a), 64'(BASE + 32'd32));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule